// File: doc/BRIEF.md
# Display Scan-Out Address Generator

This block turns the frame-timing strobes of a raster display into the sequence of 32-bit-word addresses at which a pixel fetch unit reads the frame buffer. Software programs two field start addresses, a packed window-size word and a display-mode nibble. The timing generator supplies a field-start strobe with the field parity, a line-start strobe before each visible line, and a word-advance strobe each time the fetch unit takes a word. The block answers with a word address and a valid flag.

For interlaced output, the odd field starts one line further into memory than the even field. The line stride (the modulo) then includes one extra full line, so each field reads every other line of the image. When scan doubling is on, each source line is issued twice with the same addresses. The pixel-size code is latched at field start and passed on to the unpacker. The rest of the field configuration is latched at the same moment.

The controller is a four-state machine:
- IDLE: display disabled or not yet started.
- GAP: a field is open and the block waits for a line start.
- LINE: addresses are being issued.
- DONE: every line of the field has been issued.

The transitions are:
- IDLE→GAP and any→GAP on a field start while enabled.
- GAP→LINE on a line start.
- LINE→GAP on the last word of a line when more lines, or a repeat pass, remain.
- LINE→DONE on the last word of the last line.
- any→IDLE when the enable bit is low.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset, fetch_valid_o is 0, fetch_addr_o is 0 and pix_code_o is 0.
- R2: A field start while enabled loads the address with long_start_i when field_odd_i is 0, or with short_start_i when it is 1. fetch_valid_o is 0 in the following cycle.
- R3: A line start in GAP raises fetch_valid_o with the line's first address. Each word advance adds one to the address. After width+1 advances (width-minus-one is win_size_i[9:0]), fetch_valid_o falls.
- R4: The first address of the next line equals the last word address of the previous line plus the modulo in win_size_i[29:20]. A modulo of 1 gives contiguous lines, and 1 + words-per-line skips one line.
- R5: After height+1 lines (height-minus-one is win_size_i[19:10]), no address is issued and strobes are ignored until the next field start.
- R6: The window size, pixel code and doubling bit are captured at field start. Changes to them during a field take effect only at the next field start.
- R7: pix_code_o carries disp_mode_i[3:2] as captured at field start: bytes per pixel minus one, with 1 = 16, 2 = 24 and 3 = 32 bits per pixel.
- R8: While disp_mode_i[0] (display enable) is 0, fetch_valid_o is 0 from the next cycle on and all strobes are ignored. Re-enabling needs a field start.
- R9: With disp_mode_i[1] (scan doubling) captured as 1, each line is issued twice with identical addresses. Height still counts source lines.
- R10: A field start takes priority over the other strobes and restarts the field even in the middle of a line.
- R11: A line start during LINE, and a word advance during GAP, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_start_i | input | ADDR_W | Word address of the long (even) field start |
| short_start_i | input | ADDR_W | Word address of the short (odd) field start |
| win_size_i | input | 30 | Modulo [29:20], height-1 [19:10], width-1 in words [9:0] |
| disp_mode_i | input | 4 | Pixel code [3:2], scan doubling [1], display enable [0] |
| field_start_i | input | 1 | Start-of-field strobe |
| field_odd_i | input | 1 | Field parity, sampled with field_start_i |
| line_start_i | input | 1 | Start-of-line strobe |
| word_adv_i | input | 1 | Fetch unit has taken the current word |
| fetch_addr_o | output | ADDR_W | Current word address |
| fetch_valid_o | output | 1 | fetch_addr_o is a valid read address |
| pix_code_o | output | 2 | Bytes per pixel minus one, as latched for this field |

## Verification
The bench sweeps every combination of several widths, heights, both modulo styles, both parities and both doubling settings. It checks every issued address against an arithmetic model.

- A design that mishandles the end-of-line step shows up as a first-word address offset by one, or as interlaced fields that overlap.
- A design that miscounts the window would issue one word or line too many or too few, and the bench catches the stray valid.
- Mid-field reconfiguration and a mid-line field restart would show a changed line length, a changed pixel code or a stale address.
- Strobes that arrive in the wrong state, and a dropped enable, would show as a spurious advance or a valid that never falls.

// File: rtl/sag_pkg.sv
package sag_pkg;
    localparam int FLD_W       = 10;
    localparam int WIN_W       = 3 * FLD_W;
    localparam int MOD_LSB     = 2 * FLD_W;
    localparam int HGT_LSB     = FLD_W;
    localparam int WID_LSB     = 0;
    localparam int MODE_W      = 4;
    localparam int MODE_EN_BIT = 0;
    localparam int MODE_DB_BIT = 1;
    localparam int PIX_LSB     = 2;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_GAP  = 2'd1,
        S_LINE = 2'd2,
        S_DONE = 2'd3
    } sag_state_e;

    typedef struct packed {
        logic [FLD_W-1:0] modulo;
        logic [FLD_W-1:0] height_m1;
        logic [FLD_W-1:0] width_m1;
        logic             dbl;
        logic [1:0]       pix_code;
    } sag_cfg_t;
endpackage

// File: rtl/sag_cfg_latch.sv
module sag_cfg_latch
    import sag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [WIN_W-1:0]       win_i,
    input  logic [MODE_W-1:0]      mode_i,
    output sag_cfg_t               cfg_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (load) begin
            cfg_o.modulo    <= win_i[MOD_LSB +: FLD_W];
            cfg_o.height_m1 <= win_i[HGT_LSB +: FLD_W];
            cfg_o.width_m1  <= win_i[WID_LSB +: FLD_W];
            cfg_o.dbl       <= mode_i[MODE_DB_BIT];
            cfg_o.pix_code  <= mode_i[PIX_LSB +: 2];
        end
    end
endmodule

// File: rtl/sag_limit_counter.sv
module sag_limit_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         at_limit
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + ONE;
    end

    assign at_limit = (count == limit);

    assert_count_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (count < limit));
endmodule

// File: rtl/sag_addr_fsm.sv
module sag_addr_fsm
    import sag_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              field_start,
    input  logic              field_odd,
    input  logic              line_start,
    input  logic              word_adv,
    input  logic [ADDR_W-1:0] long_start,
    input  logic [ADDR_W-1:0] short_start,
    input  sag_cfg_t          cfg,
    input  logic              w_last,
    input  logic              l_last,
    output logic              field_go,
    output logic              w_clr,
    output logic              w_inc,
    output logic              l_inc,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    sag_state_e        state_q, state_d;
    logic [ADDR_W-1:0] cur_q, base_q;
    logic              rep_q;
    logic              step, pass_done;
    logic [ADDR_W-1:0] mod_ext, next_line;

    assign field_go  = en && field_start;
    assign step      = en && !field_start && (state_q == S_LINE) && word_adv;
    assign pass_done = !cfg.dbl || rep_q;
    assign mod_ext   = {{(ADDR_W-FLD_W){1'b0}}, cfg.modulo};
    assign next_line = cur_q + mod_ext;

    assign w_clr = field_go || (state_q != S_LINE);
    assign w_inc = step && !w_last;
    assign l_inc = step && w_last && pass_done && !l_last;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = S_IDLE;
        end else if (field_start) begin
            state_d = S_GAP;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_GAP:  if (line_start) state_d = S_LINE;
                S_LINE: if (word_adv && w_last)
                            state_d = (pass_done && l_last) ? S_DONE : S_GAP;
                S_DONE: state_d = S_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            base_q <= '0;
            rep_q  <= 1'b0;
        end else if (field_go) begin
            cur_q  <= field_odd ? short_start : long_start;
            base_q <= field_odd ? short_start : long_start;
            rep_q  <= 1'b0;
        end else if (step) begin
            if (!w_last) begin
                cur_q <= cur_q + ONE;
            end else if (!pass_done) begin
                cur_q <= base_q;
                rep_q <= 1'b1;
            end else begin
                cur_q  <= next_line;
                base_q <= next_line;
                rep_q  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        fetch_addr  = cur_q;
        fetch_valid = (state_q == S_LINE);
    end

    assert_field_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        field_go |=> (!fetch_valid &&
                      fetch_addr == ($past(field_odd) ? $past(short_start) : $past(long_start))));

    assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !w_last) |=> (fetch_valid && fetch_addr == $past(fetch_addr) + ONE));

    assert_line_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && w_last && pass_done) |=> (!fetch_valid && fetch_addr == $past(fetch_addr) + mod_ext));

    assert_repeat_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && w_last && !pass_done) |=> (fetch_addr == $past(base_q)));

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && !field_go) |=> !fetch_valid);

    assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fetch_valid);
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
    import sag_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] long_start_i,
    input  logic [ADDR_W-1:0] short_start_i,
    input  logic [WIN_W-1:0]  win_size_i,
    input  logic [MODE_W-1:0] disp_mode_i,
    input  logic              field_start_i,
    input  logic              field_odd_i,
    input  logic              line_start_i,
    input  logic              word_adv_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              fetch_valid_o,
    output logic [1:0]        pix_code_o
);
    sag_cfg_t         cfg;
    logic             field_go, w_clr, w_inc, l_inc, w_last, l_last;
    logic [FLD_W-1:0] w_cnt, l_cnt;

    sag_cfg_latch u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (field_go),
        .win_i  (win_size_i),
        .mode_i (disp_mode_i),
        .cfg_o  (cfg)
    );

    sag_limit_counter #(.W(FLD_W)) u_word_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (w_clr),
        .inc      (w_inc),
        .limit    (cfg.width_m1),
        .count    (w_cnt),
        .at_limit (w_last)
    );

    sag_limit_counter #(.W(FLD_W)) u_line_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (field_go),
        .inc      (l_inc),
        .limit    (cfg.height_m1),
        .count    (l_cnt),
        .at_limit (l_last)
    );

    sag_addr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (disp_mode_i[MODE_EN_BIT]),
        .field_start (field_start_i),
        .field_odd   (field_odd_i),
        .line_start  (line_start_i),
        .word_adv    (word_adv_i),
        .long_start  (long_start_i),
        .short_start (short_start_i),
        .cfg         (cfg),
        .w_last      (w_last),
        .l_last      (l_last),
        .field_go    (field_go),
        .w_clr       (w_clr),
        .w_inc       (w_inc),
        .l_inc       (l_inc),
        .fetch_addr  (fetch_addr_o),
        .fetch_valid (fetch_valid_o)
    );

    assign pix_code_o = cfg.pix_code;

    assert_pix_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !field_go |=> $stable(pix_code_o));

    assert_pix_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        field_go |=> (pix_code_o == $past(disp_mode_i[PIX_LSB +: 2])));

    assert_counts_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_cnt <= cfg.width_m1) && (l_cnt <= cfg.height_m1));
endmodule

// File: tb/sim_scan_addr_gen.sv
module sim_scan_addr_gen;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] long_start_i = '0, short_start_i = '0;
    logic [29:0]   win_size_i = '0;
    logic [3:0]    disp_mode_i = '0;
    logic          field_start_i = 0, field_odd_i = 0, line_start_i = 0, word_adv_i = 0;
    logic [AW-1:0] fetch_addr_o;
    logic          fetch_valid_o;
    logic [1:0]    pix_code_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    scan_addr_gen #(.ADDR_W(AW)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int which);
        case (which)
            0: field_start_i = 1'b1;
            1: line_start_i  = 1'b1;
            default: word_adv_i = 1'b1;
        endcase
        @(negedge clk);
        field_start_i = 1'b0;
        line_start_i  = 1'b0;
        word_adv_i    = 1'b0;
    endtask

    function automatic logic [29:0] win(input int w, input int h, input int m);
        return {m[9:0], h[9:0], w[9:0]};
    endfunction

    // full field against the arithmetic model
    task automatic run_field(input int w, input int h, input int m, input bit par,
                             input bit dbl, input int code, input int lstart);
        int base;
        long_start_i  = AW'(lstart);
        short_start_i = AW'(lstart + w + 1);
        win_size_i    = win(w, h, m);
        disp_mode_i   = {code[1:0], dbl, 1'b1};
        field_odd_i   = par;
        pulse(0);
        base = par ? lstart + w + 1 : lstart;
        chk("R2 valid after field start", fetch_valid_o, 0);
        chk("R2 field start address", fetch_addr_o, base);
        chk("R7 pixel code", pix_code_o, code);
        for (int l = 0; l <= h; l++) begin
            for (int r = 0; r <= int'(dbl); r++) begin
                @(negedge clk);
                chk("R3 gap before line", fetch_valid_o, 0);
                pulse(1);
                for (int k = 0; k <= w; k++) begin
                    chk(r ? "R9 repeat valid" : "R3 word valid", fetch_valid_o, 1);
                    chk(l == 0 ? "R3 word address" : "R4 line address", fetch_addr_o, base + k);
                    pulse(2);
                end
                chk("R3 valid falls after width", fetch_valid_o, 0);
            end
            base = base + w + m;
        end
        pulse(1);
        chk("R5 no line after height", fetch_valid_o, 0);
        pulse(2);
        chk("R5 still quiet", fetch_valid_o, 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R1 reset valid", fetch_valid_o, 0);
        chk("R1 reset addr", fetch_addr_o, 0);
        chk("R1 reset pix code", pix_code_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep
        for (int w = 0; w < 4; w++)
            for (int h = 0; h < 3; h++)
                for (int mi = 0; mi < 2; mi++)
                    for (int p = 0; p < 2; p++)
                        for (int d = 0; d < 2; d++)
                            run_field(w, h, mi ? w + 2 : 1, p[0], d[0],
                                      1 + ((w + h) % 3), 'h1000 + 64 * w + h);

        // R6: mid-field reconfiguration
        run_field(0, 0, 1, 0, 0, 1, 'h200); // settle
        long_start_i = AW'('h300);
        win_size_i   = win(1, 0, 1);
        disp_mode_i  = 4'b0101;
        field_odd_i  = 0;
        pulse(0);
        win_size_i  = win(3, 2, 1);
        disp_mode_i = 4'b1111;
        @(negedge clk);
        chk("R6 pix code held", pix_code_o, 1);
        pulse(1);
        pulse(2);
        chk("R6 second word", fetch_addr_o, 'h301);
        pulse(2);
        chk("R6 width held", fetch_valid_o, 0);
        pulse(1);
        chk("R6 height held", fetch_valid_o, 0);
        pulse(0);
        chk("R6 new code at field start", pix_code_o, 3);

        // R10: restart mid-line
        long_start_i  = AW'('h400);
        short_start_i = AW'('h480);
        win_size_i    = win(3, 1, 1);
        disp_mode_i   = 4'b1001;
        field_odd_i   = 0;
        pulse(0);
        pulse(1);
        pulse(2);
        pulse(2);
        chk("R10 mid line addr", fetch_addr_o, 'h402);
        field_odd_i = 1;
        pulse(0);
        chk("R10 restart valid", fetch_valid_o, 0);
        chk("R10 restart addr", fetch_addr_o, 'h480);

        // R11: misplaced strobes
        pulse(2);
        chk("R11 advance in gap", fetch_valid_o, 0);
        pulse(1);
        chk("R11 line addr after stray advance", fetch_addr_o, 'h480);
        pulse(2);
        pulse(1);
        chk("R11 line start in line valid", fetch_valid_o, 1);
        chk("R11 line start in line addr", fetch_addr_o, 'h481);

        // R8: enable low
        disp_mode_i = 4'b1000;
        @(negedge clk);
        chk("R8 disable drops valid", fetch_valid_o, 0);
        pulse(0);
        pulse(1);
        chk("R8 strobes ignored", fetch_valid_o, 0);
        disp_mode_i = 4'b1001;
        pulse(1);
        chk("R8 needs field start", fetch_valid_o, 0);
        pulse(0);
        pulse(1);
        chk("R8 resumes after field start", fetch_valid_o, 1);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule